// File: doc/BRIEF.md
# I2C Controller Transaction Sequencer

This block runs one complete I2C controller transfer on top of a separate bit-level line engine. It takes a target address, an addressing mode (7-bit or 10-bit), a direction bit, transmit and receive byte counts and a timeout. After a start pulse it issues START, address header, data and STOP commands to the line engine one at a time. Each command is held until the engine acknowledges it. Transmit bytes arrive on a valid/ready stream. Received bytes leave on another valid/ready stream.

Three transfer shapes are supported. A write-only transfer has the direction bit clear and a zero receive count. A read-only transfer has the direction bit set. A combined transfer has the direction bit clear and a nonzero receive count: the bytes are written, then a repeated START is issued, the header is sent again with the read bit set, and the bytes are read. The transfer ends with a single-cycle done pulse and a status code. A deadline counted in clock cycles from the start pulse is checked before every byte. When the deadline is hit, the sequencer sends a STOP and reports a timeout.

Top module: `i2cs_seq`

## Requirements
- R1: After reset, `done_o`, `cmd_valid_o`, `tx_ready_o` and `rx_valid_o` are all 0.
- R2: A `start_i` pulse while idle makes START (`cmd_o`=1) the first command. A `start_i` pulse while a transfer is running has no effect.
- R3: In 7-bit mode the header byte is address[6:0] followed by the direction bit in the least significant position (1 = read).
- R4: In 10-bit mode the header is two bytes. The first is binary 11110, then address[9:8], then the direction bit. The second is address[7:0]. After a repeated START only the first byte is sent, with the direction bit set to 1.
- R5: Every written byte is sent as eight WRITE commands (`cmd_o`=4, value on `cmd_bit_o`), most significant bit first, then one READ command (`cmd_o`=5). If that read returns 1, the status is ACK failure, a STOP follows, and no further bytes are taken or sent.
- R6: Every read byte is eight READ commands, most significant bit first, then a WRITE of 0. The last byte of the transfer gets a WRITE of 1 instead. The byte is offered on `rx_data_o` and held with `rx_valid_o` until `rx_ready_i`.
- R7: In a combined transfer the last transmit byte is followed by RESTART (`cmd_o`=2), the read header and the read phase. A write-only transfer follows its last byte with STOP (`cmd_o`=3).
- R8: A transmit count of 0 in write mode, or a receive count of 0 in read mode, moves one byte.
- R9: A timeout of T means the deadline expires T cycles after the start pulse. The deadline is checked before each byte, including while the sequencer waits for transmit data. On expiry the sequencer sends STOP and reports timeout. A timeout of all ones never expires.
- R10: If the line engine reports lost arbitration on any command, the transfer ends at once with no further command and status arbitration lost.
- R11: Every transfer ends with `done_o` high for exactly one cycle. The status codes on `status_o` are OK=0, timeout=1, ACK failure=2, arbitration lost=3.
- R12: A command stays valid and unchanged until `bit_done_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| addr_i | input | 10 | Target address |
| ten_bit_i | input | 1 | 1 = 10-bit addressing |
| read_i | input | 1 | 1 = read-only transfer |
| tx_cnt_i | input | CNT_W | Bytes to write |
| rx_cnt_i | input | CNT_W | Bytes to read |
| timeout_i | input | TO_W | Deadline in cycles; all ones = none |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte taken |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Receiver ready |
| done_o | output | 1 | End-of-transfer pulse |
| status_o | output | 2 | Result code |
| cmd_o | output | 3 | Line command: 1 START, 2 RESTART, 3 STOP, 4 WRITE, 5 READ |
| cmd_bit_o | output | 1 | Bit value for WRITE |
| cmd_valid_o | output | 1 | Command pending |
| bit_done_i | input | 1 | Line engine finished the command |
| bit_rd_i | input | 1 | Sampled line value for READ |
| arb_lost_i | input | 1 | Arbitration lost during the command |

## Verification
The hardest case to reach is a deadline that expires between bytes rather than at the first check. The header is already sent, and the sequencer must give up on the missing data byte, send STOP and never take that byte. The bench reaches this case by withholding the transmit stream after the header, with a deadline longer than the header but shorter than the stall. A companion run uses the all-ones timeout and a longer stall, then releases the data, to show that the transfer still finishes normally. The line engine model can also inject NACKs at a chosen byte and lost arbitration at a chosen command index. This exercises the mid-transfer aborts.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 10;

  typedef enum logic [2:0] {
    LC_NONE    = 3'd0,
    LC_START   = 3'd1,
    LC_RESTART = 3'd2,
    LC_STOP    = 3'd3,
    LC_WRITE   = 3'd4,
    LC_READ    = 3'd5
  } line_cmd_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_ACKFAIL = 2'd2,
    ST_ARBLOST = 2'd3
  } xfer_status_e;

  typedef enum logic [1:0] {
    BK_HDR0,
    BK_HDR1,
    BK_TX,
    BK_RX
  } byte_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_CHECK,
    SQ_BYTE,
    SQ_RXOUT,
    SQ_RESTART,
    SQ_STOP,
    SQ_DONE
  } seq_state_e;

endpackage

// File: rtl/i2cs_deadline.sv
module i2cs_deadline #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);

  localparam logic [TO_W-1:0] NEVER = '1;

  logic [TO_W-1:0] remain_q, remain_d;
  logic            inf_q, inf_d;

  always_comb begin
    remain_d = remain_q;
    inf_d    = inf_q;
    if (load_i) begin
      remain_d = limit_i;
      inf_d    = (limit_i == NEVER);
    end else if (remain_q != '0) begin
      remain_d = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      inf_q    <= 1'b0;
    end else begin
      remain_q <= remain_d;
      inf_q    <= inf_d;
    end
  end

  assign expired_o = !inf_q && (remain_q == '0);

  assert_fresh_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && limit_i > 1) |=> !expired_o ##1 !expired_o);

endmodule

// File: rtl/i2cs_hdr_gen.sv
module i2cs_hdr_gen
  import i2cs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ten_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] first_o,
  output logic [BYTE_W-1:0] second_o
);

  localparam logic [4:0] TEN_MARK = 5'b11110;

  always_comb begin
    if (ten_i) first_o = {TEN_MARK, addr_i[9:8], rd_i};
    else       first_o = {addr_i[6:0], rd_i};
    second_o = addr_i[7:0];
  end

endmodule

// File: rtl/i2cs_byte_io.sv
module i2cs_byte_io
  import i2cs_pkg::*;
#(
  parameter int unsigned NBITS = BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             rd_i,
  input  logic             nack_i,
  input  logic [NBITS-1:0] wbyte_i,
  input  logic             bit_done_i,
  input  logic             bit_rd_i,
  input  logic             arb_lost_i,
  output logic             busy_o,
  output line_cmd_e        cmd_o,
  output logic             cmd_bit_o,
  output logic             fin_o,
  output logic             fin_arb_o,
  output logic             fin_ack_o,
  output logic [NBITS-1:0] rbyte_o
);

  localparam int unsigned IDX_W = $clog2(NBITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS);

  logic             busy_q, busy_d;
  logic             rd_q, rd_d;
  logic             nack_q, nack_d;
  logic [NBITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             fin_q, fin_d;
  logic             farb_q, farb_d;
  logic             fack_q, fack_d;
  logic             data_phase;

  assign data_phase = (idx_q < LAST_IDX);

  always_comb begin
    if (rd_q) begin
      cmd_o     = data_phase ? LC_READ : LC_WRITE;
      cmd_bit_o = data_phase ? 1'b0 : nack_q;
    end else begin
      cmd_o     = data_phase ? LC_WRITE : LC_READ;
      cmd_bit_o = data_phase ? sh_q[NBITS-1] : 1'b0;
    end
  end

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    nack_d = nack_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    fin_d  = 1'b0;
    farb_d = farb_q;
    fack_d = fack_q;
    if (!busy_q) begin
      if (go_i) begin
        busy_d = 1'b1;
        rd_d   = rd_i;
        nack_d = nack_i;
        sh_d   = wbyte_i;
        idx_d  = '0;
      end
    end else if (bit_done_i) begin
      if (arb_lost_i) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
        farb_d = 1'b1;
        fack_d = 1'b0;
      end else if (data_phase) begin
        sh_d  = {sh_q[NBITS-2:0], rd_q ? bit_rd_i : 1'b0};
        idx_d = idx_q + 1'b1;
      end else begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
        farb_d = 1'b0;
        fack_d = rd_q ? 1'b0 : bit_rd_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      nack_q <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      fin_q  <= 1'b0;
      farb_q <= 1'b0;
      fack_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      nack_q <= nack_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      fin_q  <= fin_d;
      farb_q <= farb_d;
      fack_q <= fack_d;
    end
  end

  assign busy_o    = busy_q;
  assign fin_o     = fin_q;
  assign fin_arb_o = farb_q;
  assign fin_ack_o = fack_q;
  assign rbyte_o   = sh_q;

  assert_go_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q);
  assert_bit_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= LAST_IDX));
  assert_fin_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !busy_q);

endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TO_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                ten_bit_i,
  input  logic                read_i,
  input  logic [CNT_W-1:0]    tx_cnt_i,
  input  logic [CNT_W-1:0]    rx_cnt_i,
  input  logic [TO_W-1:0]     timeout_i,
  input  logic [BYTE_W-1:0]   tx_data_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  output logic [BYTE_W-1:0]   rx_data_o,
  output logic                rx_valid_o,
  input  logic                rx_ready_i,
  output logic                done_o,
  output logic [1:0]          status_o,
  output logic [2:0]          cmd_o,
  output logic                cmd_bit_o,
  output logic                cmd_valid_o,
  input  logic                bit_done_i,
  input  logic                bit_rd_i,
  input  logic                arb_lost_i
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  seq_state_e          st_q, st_d;
  byte_kind_e          kind_q, kind_d;
  xfer_status_e        stat_q, stat_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                ten_q, ten_d;
  logic                rd_q, rd_d;
  logic                rs_q, rs_d;
  logic                follow_q, follow_d;
  logic [CNT_W-1:0]    txl_q, txl_d;
  logic [CNT_W-1:0]    rxl_q, rxl_d;
  logic [BYTE_W-1:0]   rxb_q, rxb_d;

  logic                tmr_load, expired;
  logic [BYTE_W-1:0]   hdr_first, hdr_second;
  logic                sh_go, sh_rd, sh_nack;
  logic [BYTE_W-1:0]   sh_wbyte, sh_rbyte;
  logic                sh_busy, sh_bit, sh_fin, sh_farb, sh_fack;
  line_cmd_e           sh_cmd, top_cmd;
  logic                top_valid;

  i2cs_deadline #(.TO_W(TO_W)) u_deadline (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .limit_i(timeout_i),
    .expired_o(expired)
  );

  i2cs_hdr_gen u_hdr (
    .addr_i(addr_q), .ten_i(ten_q), .rd_i(rd_q),
    .first_o(hdr_first), .second_o(hdr_second)
  );

  i2cs_byte_io #(.NBITS(BYTE_W)) u_byte (
    .clk(clk), .rst_n(rst_n), .go_i(sh_go), .rd_i(sh_rd), .nack_i(sh_nack),
    .wbyte_i(sh_wbyte), .bit_done_i(bit_done_i), .bit_rd_i(bit_rd_i),
    .arb_lost_i(arb_lost_i), .busy_o(sh_busy), .cmd_o(sh_cmd),
    .cmd_bit_o(sh_bit), .fin_o(sh_fin), .fin_arb_o(sh_farb),
    .fin_ack_o(sh_fack), .rbyte_o(sh_rbyte)
  );

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    stat_d   = stat_q;
    addr_d   = addr_q;
    ten_d    = ten_q;
    rd_d     = rd_q;
    rs_d     = rs_q;
    follow_d = follow_q;
    txl_d    = txl_q;
    rxl_d    = rxl_q;
    rxb_d    = rxb_q;
    tmr_load = 1'b0;
    sh_go    = 1'b0;
    sh_rd    = 1'b0;
    sh_nack  = 1'b0;
    sh_wbyte = '0;
    top_cmd  = LC_NONE;
    top_valid = 1'b0;
    tx_ready_o = 1'b0;
    rx_valid_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          tmr_load = 1'b1;
          addr_d   = addr_i;
          ten_d    = ten_bit_i;
          rd_d     = read_i;
          rs_d     = 1'b0;
          stat_d   = ST_OK;
          txl_d    = (tx_cnt_i == '0) ? ONE : tx_cnt_i;
          rxl_d    = (read_i && rx_cnt_i == '0) ? ONE : rx_cnt_i;
          follow_d = !read_i && (rx_cnt_i != '0);
          st_d     = SQ_START;
        end
      end
      SQ_START, SQ_RESTART: begin
        top_valid = 1'b1;
        top_cmd   = (st_q == SQ_START) ? LC_START : LC_RESTART;
        if (bit_done_i) begin
          if (arb_lost_i) begin
            stat_d = ST_ARBLOST;
            st_d   = SQ_DONE;
          end else begin
            kind_d = BK_HDR0;
            st_d   = SQ_CHECK;
          end
        end
      end
      SQ_CHECK: begin
        if (expired) begin
          stat_d = ST_TIMEOUT;
          st_d   = SQ_STOP;
        end else begin
          unique case (kind_q)
            BK_HDR0: begin sh_go = 1'b1; sh_wbyte = hdr_first; end
            BK_HDR1: begin sh_go = 1'b1; sh_wbyte = hdr_second; end
            BK_TX: begin
              tx_ready_o = 1'b1;
              sh_go      = tx_valid_i;
              sh_wbyte   = tx_data_i;
            end
            default: begin
              sh_go   = 1'b1;
              sh_rd   = 1'b1;
              sh_nack = (rxl_q == ONE);
            end
          endcase
          if (sh_go) st_d = SQ_BYTE;
        end
      end
      SQ_BYTE: begin
        if (sh_fin) begin
          if (sh_farb) begin
            stat_d = ST_ARBLOST;
            st_d   = SQ_DONE;
          end else if (kind_q != BK_RX && sh_fack) begin
            stat_d = ST_ACKFAIL;
            st_d   = SQ_STOP;
          end else begin
            unique case (kind_q)
              BK_HDR0: begin
                st_d = SQ_CHECK;
                if (ten_q && !rs_q) kind_d = BK_HDR1;
                else                kind_d = rd_q ? BK_RX : BK_TX;
              end
              BK_HDR1: begin
                st_d   = SQ_CHECK;
                kind_d = rd_q ? BK_RX : BK_TX;
              end
              BK_TX: begin
                if (txl_q == ONE) begin
                  if (follow_q) begin
                    rd_d = 1'b1;
                    rs_d = 1'b1;
                    st_d = SQ_RESTART;
                  end else begin
                    st_d = SQ_STOP;
                  end
                end else begin
                  txl_d = txl_q - 1'b1;
                  st_d  = SQ_CHECK;
                end
              end
              default: begin
                rxb_d = sh_rbyte;
                st_d  = SQ_RXOUT;
              end
            endcase
          end
        end
      end
      SQ_RXOUT: begin
        rx_valid_o = 1'b1;
        if (rx_ready_i) begin
          if (rxl_q == ONE) begin
            st_d = SQ_STOP;
          end else begin
            rxl_d = rxl_q - 1'b1;
            st_d  = SQ_CHECK;
          end
        end
      end
      SQ_STOP: begin
        top_valid = 1'b1;
        top_cmd   = LC_STOP;
        if (bit_done_i) begin
          if (arb_lost_i) stat_d = ST_ARBLOST;
          st_d = SQ_DONE;
        end
      end
      default: begin
        st_d = SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      kind_q   <= BK_HDR0;
      stat_q   <= ST_OK;
      addr_q   <= '0;
      ten_q    <= 1'b0;
      rd_q     <= 1'b0;
      rs_q     <= 1'b0;
      follow_q <= 1'b0;
      txl_q    <= '0;
      rxl_q    <= '0;
      rxb_q    <= '0;
    end else begin
      st_q     <= st_d;
      kind_q   <= kind_d;
      stat_q   <= stat_d;
      addr_q   <= addr_d;
      ten_q    <= ten_d;
      rd_q     <= rd_d;
      rs_q     <= rs_d;
      follow_q <= follow_d;
      txl_q    <= txl_d;
      rxl_q    <= rxl_d;
      rxb_q    <= rxb_d;
    end
  end

  assign cmd_valid_o = top_valid | sh_busy;
  assign cmd_o       = sh_busy ? sh_cmd : top_cmd;
  assign cmd_bit_o   = sh_busy ? sh_bit : 1'b0;
  assign rx_data_o   = rxb_q;
  assign done_o      = (st_q == SQ_DONE);
  assign status_o    = stat_q;

  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !bit_done_i) |=>
      (cmd_valid_o && $stable(cmd_o) && $stable(cmd_bit_o)));
  assert_single_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_valid && sh_busy));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
  assert_no_late_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> !expired);
  assert_stop_arb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_STOP && bit_done_i && arb_lost_i) |=>
      (done_o && status_o == 2'd3));

endmodule

// File: tb/i2cs_seq_tb_top.sv
`timescale 1ns/1ps
module i2cs_seq_tb_top;

  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [9:0] addr_i;
  logic       ten_bit_i, read_i;
  logic [7:0] tx_cnt_i, rx_cnt_i, timeout_i;
  logic [7:0] tx_data_i;
  logic       tx_valid_i, tx_ready_o;
  logic [7:0] rx_data_o;
  logic       rx_valid_o, rx_ready_i;
  logic       done_o;
  logic [1:0] status_o;
  logic [2:0] cmd_o;
  logic       cmd_bit_o, cmd_valid_o;
  logic       bit_done_i, bit_rd_i, arb_lost_i;

  always #4 clk = ~clk;

  i2cs_seq #(.CNT_W(8), .TO_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .ten_bit_i(ten_bit_i), .read_i(read_i), .tx_cnt_i(tx_cnt_i),
    .rx_cnt_i(rx_cnt_i), .timeout_i(timeout_i), .tx_data_i(tx_data_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .done_o(done_o),
    .status_o(status_o), .cmd_o(cmd_o), .cmd_bit_o(cmd_bit_o),
    .cmd_valid_o(cmd_valid_o), .bit_done_i(bit_done_i), .bit_rd_i(bit_rd_i),
    .arb_lost_i(arb_lost_i)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  string      cur_req = "R1";
  int         exp_q[$];
  bit         rd_q[$];
  logic [7:0] rxexp_q[$];
  logic [7:0] tx_q[$];
  bit         tx_hold = 1'b0;
  bit         tx_pop = 1'b0;
  int         cmd_idx = 0;
  int         arb_at = -1;
  int         done_cnt = 0;
  logic [1:0] exp_st = 2'd0;
  int         cyc = 0;
  int         e_item;
  bit         e_val, e_arb;
  logic [2:0] g_cmd;
  logic       g_bit;

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, expv);
    end
  endtask

  task automatic e_cmd(input int c, input bit b);
    exp_q.push_back(c * 2 + int'(b));
  endtask

  task automatic e_wb(input logic [7:0] v, input bit ack);
    for (int i = 7; i >= 0; i--) e_cmd(4, v[i]);
    e_cmd(5, 1'b0);
    rd_q.push_back(ack);
  endtask

  task automatic e_rb(input logic [7:0] v, input bit last);
    for (int i = 7; i >= 0; i--) begin
      e_cmd(5, 1'b0);
      rd_q.push_back(v[i]);
    end
    e_cmd(4, last);
    rxexp_q.push_back(v);
  endtask

  // line engine model and command scoreboard (R12 handshake)
  initial begin
    bit_done_i = 1'b0; bit_rd_i = 1'b1; arb_lost_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid_o) begin
        g_cmd = cmd_o;
        g_bit = cmd_bit_o;
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected command", int'(g_cmd), 0);
        end else begin
          e_item = exp_q.pop_front();
          check((e_item / 2 == int'(g_cmd)) &&
                (g_cmd != 3'd4 || (e_item % 2) == int'(g_bit)),
                "command/bit", int'(g_cmd) * 2 + int'(g_bit), e_item);
        end
        e_val = 1'b1;
        if (g_cmd == 3'd5 && rd_q.size() > 0) e_val = rd_q.pop_front();
        e_arb = (cmd_idx == arb_at);
        cmd_idx++;
        repeat (LAT - 1) @(negedge clk);
        check(cmd_valid_o && cmd_o == g_cmd, "command held (R12)", int'(cmd_o), int'(g_cmd));
        bit_done_i = 1'b1; bit_rd_i = e_val; arb_lost_i = e_arb;
        @(negedge clk);
        bit_done_i = 1'b0; bit_rd_i = 1'b1; arb_lost_i = 1'b0;
      end
    end
  end

  // transmit stream driver
  initial begin
    tx_valid_i = 1'b0; tx_data_i = '0;
    forever begin
      @(negedge clk);
      if (tx_pop && tx_q.size() > 0) void'(tx_q.pop_front());
      tx_pop = 1'b0;
      tx_valid_i = (tx_q.size() > 0) && !tx_hold;
      tx_data_i  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
      if (tx_valid_i && tx_ready_o) tx_pop = 1'b1;
    end
  end

  // receive stream and done monitor
  initial begin
    rx_ready_i = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      rx_ready_i = (cyc % 3) != 1;
      if (rst_n && rx_valid_o && rx_ready_i) begin
        if (rxexp_q.size() == 0) check(1'b0, "unexpected rx byte", int'(rx_data_o), 0);
        else begin
          e_item = int'(rxexp_q.pop_front());
          check(int'(rx_data_o) == e_item, "rx byte (R6)", int'(rx_data_o), e_item);
        end
      end
      if (rst_n && done_o) begin
        done_cnt++;
        check(status_o == exp_st, "status (R11)", int'(status_o), int'(exp_st));
      end
    end
  end

  task automatic run(input string req, input logic [9:0] a, input bit ten, input bit rd,
                     input logic [7:0] txn, input logic [7:0] rxn, input logic [7:0] to,
                     input logic [1:0] est, input bit ghost);
    cur_req = req; exp_st = est; done_cnt = 0; cmd_idx = 0;
    @(negedge clk);
    addr_i = a; ten_bit_i = ten; read_i = rd; tx_cnt_i = txn; rx_cnt_i = rxn;
    timeout_i = to; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (ghost) begin
      // R2: a start pulse mid-transfer must not disturb anything
      repeat (20) @(negedge clk);
      addr_i = ~a; read_i = ~rd; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "commands left unissued", exp_q.size(), 0);
    check(rxexp_q.size() == 0, "rx bytes missing", rxexp_q.size(), 0);
    check(done_cnt == 1, "done pulse count", done_cnt, 1);
    arb_at = -1;
    rd_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog %s: actual hung expected done", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; ten_bit_i = 1'b0; read_i = 1'b0;
    tx_cnt_i = '0; rx_cnt_i = '0; timeout_i = '1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check(!done_o && !cmd_valid_o && !tx_ready_o && !rx_valid_o, "reset outputs",
          {done_o, cmd_valid_o, tx_ready_o, rx_valid_o}, 0);

    // R2 R3 R5 R7: 7-bit write, two bytes, with an ignored start pulse
    e_cmd(1, 0); e_wb(8'hB4, 0); e_wb(8'hA5, 0); e_wb(8'h3C, 0); e_cmd(3, 0);
    tx_q.push_back(8'hA5); tx_q.push_back(8'h3C);
    run("R2/R3/R7", 10'h05A, 0, 0, 8'd2, 8'd0, 8'hFF, 2'd0, 1);

    // R3 R6: 7-bit read of three bytes, last one NACKed
    e_cmd(1, 0); e_wb(8'h43, 0); e_rb(8'h96, 0); e_rb(8'h0F, 0); e_rb(8'hF1, 1); e_cmd(3, 0);
    run("R3/R6", 10'h021, 0, 1, 8'd0, 8'd3, 8'hFF, 2'd0, 0);

    // R4 R7: 10-bit combined, header resent as single byte after restart
    e_cmd(1, 0); e_wb(8'hF4, 0); e_wb(8'hC5, 0); e_wb(8'h77, 0);
    e_cmd(2, 0); e_wb(8'hF5, 0); e_rb(8'h5E, 0); e_rb(8'hA1, 1); e_cmd(3, 0);
    tx_q.push_back(8'h77);
    run("R4/R7", 10'h2C5, 1, 0, 8'd1, 8'd2, 8'hFF, 2'd0, 0);

    // R4: 10-bit read-only sends both header bytes, read bit in the first
    e_cmd(1, 0); e_wb(8'hF3, 0); e_wb(8'h3A, 0); e_rb(8'hC3, 1); e_cmd(3, 0);
    run("R4", 10'h13A, 1, 1, 8'd0, 8'd1, 8'hFF, 2'd0, 0);

    // R8: zero counts move one byte
    e_cmd(1, 0); e_wb(8'h22, 0); e_wb(8'hE2, 0); e_cmd(3, 0);
    tx_q.push_back(8'hE2);
    run("R8", 10'h011, 0, 0, 8'd0, 8'd0, 8'hFF, 2'd0, 0);
    e_cmd(1, 0); e_wb(8'h23, 0); e_rb(8'h4D, 1); e_cmd(3, 0);
    run("R8", 10'h011, 0, 1, 8'd0, 8'd0, 8'hFF, 2'd0, 0);

    // R5: NACK on second data byte, third byte never taken
    e_cmd(1, 0); e_wb(8'h90, 0); e_wb(8'h11, 0); e_wb(8'h22, 1); e_cmd(3, 0);
    tx_q.push_back(8'h11); tx_q.push_back(8'h22); tx_q.push_back(8'h33);
    run("R5", 10'h048, 0, 0, 8'd3, 8'd0, 8'hFF, 2'd2, 0);
    check(tx_q.size() == 1, "R5 unsent bytes left in stream", tx_q.size(), 1);
    tx_q.delete();

    // R5: NACK on the address header
    e_cmd(1, 0); e_wb(8'h7E, 1); e_cmd(3, 0);
    tx_q.push_back(8'h55);
    run("R5", 10'h03F, 0, 0, 8'd1, 8'd0, 8'hFF, 2'd2, 0);
    check(tx_q.size() == 1, "R5 data kept after header NACK", tx_q.size(), 1);
    tx_q.delete();

    // R9: zero timeout expires at the first byte check
    e_cmd(1, 0); e_cmd(3, 0);
    tx_q.push_back(8'h66);
    run("R9", 10'h010, 0, 0, 8'd1, 8'd0, 8'd0, 2'd1, 0);
    check(tx_q.size() == 1, "R9 byte not taken on timeout", tx_q.size(), 1);
    tx_q.delete();

    // R9: deadline hit while the transmit stream is starved after the header
    tx_hold = 1'b1;
    e_cmd(1, 0); e_wb(8'h20, 0); e_cmd(3, 0);
    tx_q.push_back(8'h99);
    run("R9", 10'h010, 0, 0, 8'd1, 8'd0, 8'd150, 2'd1, 0);
    check(tx_q.size() == 1, "R9 stalled byte not taken", tx_q.size(), 1);
    tx_q.delete();

    // R9: all-ones timeout never expires, even across a long stall
    e_cmd(1, 0); e_wb(8'h20, 0); e_wb(8'h99, 0); e_cmd(3, 0);
    tx_q.push_back(8'h99);
    fork
      begin repeat (400) @(negedge clk); tx_hold = 1'b0; end
    join_none
    run("R9", 10'h010, 0, 0, 8'd1, 8'd0, 8'hFF, 2'd0, 0);

    // R10: arbitration lost on START, then on the fourth header bit, then on STOP
    arb_at = 0;
    e_cmd(1, 0);
    run("R10", 10'h010, 0, 1, 8'd0, 8'd1, 8'hFF, 2'd3, 0);
    arb_at = 4;
    e_cmd(1, 0); e_cmd(4, 1); e_cmd(4, 1); e_cmd(4, 0); e_cmd(4, 1);
    run("R10", 10'h06A, 0, 1, 8'd0, 8'd1, 8'hFF, 2'd3, 0);
    arb_at = 19;
    e_cmd(1, 0); e_wb(8'h14, 0); e_wb(8'h5A, 0); e_cmd(3, 0);
    tx_q.push_back(8'h5A);
    run("R10/R11", 10'h00A, 0, 0, 8'd1, 8'd0, 8'hFF, 2'd3, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule